// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block runs a block-granular erase on a raw NAND flash bus. A single request names between one and four target blocks, one for each plane. For each target, in turn, the block sends the erase-setup command with the command latch high. It then sends the block's address bytes with the address latch high. When every target has been queued, it sends one confirm command. The block then waits for the flash's ready/busy line to fall and rise again. Each command and address byte is latched by the flash on the rising edge of the write strobe.

The address bytes carry the page-select field as zeros, and the flash ignores those bits. The block-select field sits above that page field. The byte offset inside a page is never sent.

If the request asks for it, the block then sends a status-read command and takes one byte with a single read strobe. Bit 0 of that byte reports the erase result. A busy line that never returns high is caught by a cycle-count limit.

Requests arrive on a valid/ready port. `req_ready` is high only while the sequencer is idle, and a request transfers on a clock edge where both `req_valid` and `req_ready` are high. A source may hold `req_valid` high for as long as it likes. Nothing is taken while `req_ready` is low, and fields presented during that time are dropped rather than queued. Results are plain status pins, valid from the `done` pulse until the next accepted request.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, chip enable, write strobe and read strobe are all high (inactive). Both latch enables are low, `busy` is 0 and `req_ready` is 1.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. From the next cycle, `busy` is 1 and `req_ready` is 0 until the sequence ends. A request offered while busy has no effect on the bus traffic or on the results.
- R3: Each target begins with command byte 0x60, latched with CLE=1 and ALE=0 on a rising edge of the write strobe.
- R4: Each target's address is sent as two bytes with ALE=1 and CLE=0. The first byte is {block[3:0], 4'b0000}, with the page-select bits sent as zero in the low nibble. The second byte is {3'b000, block[8:4]}.
- R5: `req_planes` = n−1 selects n targets (1 to 4). Targets are sent in order of index 0 upward, and target i takes `req_blocks[9*i +: 9]`.
- R6: Exactly one confirm command 0xD0 (CLE=1) follows the last target's address bytes.
- R7: After the confirm command, no further bus cycle is issued and `done` is not raised until the ready/busy line has been seen high again, after a fixed hold-off.
- R8: When `req_status_en`=1, one status command follows the erase: 0x70 if `cfg_status_alt` was 0 at acceptance, 0x71 if it was 1. When `req_status_en`=0, no status command is issued.
- R9: The status byte is taken with a single read-strobe low pulse while the data bus is released. It appears on `status_byte`, and `erase_fail` equals its bit 0.
- R10: If the ready/busy line stays low for TIMEOUT_CYC cycles after the hold-off, `timeout` becomes 1, no status read is made, and `erase_fail` stays 0.
- R11: `done` is a one-cycle pulse at the end of each sequence. `erase_fail`, `timeout` and `status_byte` are cleared on acceptance and hold their values from `done` until the next accepted request.
- R12: CLE and ALE are never high together, the two strobes are never low together, and the data bus is driven whenever the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_planes | input | 2 | Number of targets minus one |
| req_blocks | input | 36 | Four 9-bit block numbers, target 0 in the low bits |
| req_status_en | input | 1 | Perform a status read after the erase |
| cfg_status_alt | input | 1 | Select the alternate status command (0x71) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus value to drive |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus value from the flash |
| nand_rb_n | input | 1 | Ready/busy from the flash, low while busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| erase_fail | output | 1 | Status bit 0 from the last read |
| timeout | output | 1 | Ready/busy did not return in time |
| status_byte | output | 8 | Last status byte read |

## Verification
The sweep covers every target count, with the status read on and off and both status commands. It uses block numbers made arithmetically distinct per target, so a swapped target order, a wrong nibble split or a missing confirm shows up in the recorded bus log. Status values alternate bit 0, which tells a pass result from a fail, and the all-zero and all-one block numbers exercise the edges of the address packing. A flash model that never releases ready/busy separates the timeout path from the normal end. A second request offered mid-sequence with different fields shows that such a request is dropped: the log and results must still match the first request.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_CONF, ST_WAIT, ST_STCMD, ST_STRD, ST_FIN
  } seq_state_t;

  typedef enum logic [1:0] {W_OFF, W_HOLD, W_POLL} rb_phase_t;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STAT        = 8'h70;
  localparam logic [7:0] CMD_STAT_ALT    = 8'h71;
endpackage

// File: rtl/nand_addr_pack.sv
module nand_addr_pack #(
  parameter int BLK_W    = 9,
  parameter int PAGE_W   = 4,
  parameter int ADDR_CYC = 2
) (
  input  logic [BLK_W-1:0]      blk,
  output logic [ADDR_CYC*8-1:0] bytes_o
);
  localparam int FIELD_W = BLK_W + PAGE_W;
  localparam int BUS_W   = ADDR_CYC * 8;

  logic [FIELD_W-1:0] field;
  assign field = {blk, {PAGE_W{1'b0}}};

  generate
    for (genvar g = 0; g < ADDR_CYC; g++) begin : g_byte
      for (genvar b = 0; b < 8; b++) begin : g_bit
        if (g * 8 + b < FIELD_W) begin : g_live
          assign bytes_o[g*8+b] = field[g*8+b];
        end else begin : g_pad
          assign bytes_o[g*8+b] = 1'b0;
        end
      end
    end
  endgenerate

  initial begin
    if (FIELD_W > BUS_W) $error("address field wider than address cycles");
  end
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe #(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd,
  output logic active,
  output logic we_n,
  output logic re_n,
  output logic sample,
  output logic fin
);
  localparam int TOT = LOW_CYC + HIGH_CYC;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          low_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      rd_q   <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        rd_q   <= rd;
      end
    end else if (cnt == CW'(TOT - 1)) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign low_ph = active && (cnt < CW'(LOW_CYC));
  assign we_n   = !(low_ph && !rd_q);
  assign re_n   = !(low_ph && rd_q);
  assign sample = active && rd_q && (cnt == CW'(LOW_CYC - 1));
  assign fin    = active && (cnt == CW'(TOT - 1));

  initial begin
    if (LOW_CYC < 1 || HIGH_CYC < 1) $error("strobe phases must be at least one cycle");
  end
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait
  import nand_erase_pkg::*;
#(
  parameter int WB_CYC      = 10,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb_n,
  output logic ok,
  output logic expired
);
  localparam int MAXC = (WB_CYC > TIMEOUT_CYC) ? WB_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [1:0]    sync;
  logic          rb_s;
  rb_phase_t     ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rb_n};
  end
  assign rb_s = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= W_OFF;
      cnt <= '0;
    end else begin
      case (ph)
        W_OFF: if (start) begin
          ph  <= W_HOLD;
          cnt <= '0;
        end
        W_HOLD: if (cnt == CW'(WB_CYC - 1)) begin
          ph  <= W_POLL;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        W_POLL: if (rb_s || cnt == CW'(TIMEOUT_CYC - 1)) begin
          ph  <= W_OFF;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: ph <= W_OFF;
      endcase
    end
  end

  assign ok      = (ph == W_POLL) && rb_s;
  assign expired = (ph == W_POLL) && !rb_s && (cnt == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int MAX_PLANES  = 4,
  parameter int BLK_W       = 9,
  parameter int PAGE_W      = 4,
  parameter int WE_LOW      = 3,
  parameter int WE_HIGH     = 2,
  parameter int WB_CYC      = 10,
  parameter int TIMEOUT_CYC = 500000,
  localparam int PL_W       = (MAX_PLANES > 1) ? $clog2(MAX_PLANES) : 1,
  localparam int ADDR_CYC   = (BLK_W + PAGE_W + 7) / 8,
  localparam int AIDX_W     = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PL_W-1:0]             req_planes,
  input  logic [MAX_PLANES*BLK_W-1:0] req_blocks,
  input  logic                        req_status_en,
  input  logic                        cfg_status_alt,
  output logic                        nand_ce_n,
  output logic                        nand_cle,
  output logic                        nand_ale,
  output logic                        nand_we_n,
  output logic                        nand_re_n,
  output logic [7:0]                  nand_dq_out,
  output logic                        nand_dq_oe,
  input  logic [7:0]                  nand_dq_in,
  input  logic                        nand_rb_n,
  output logic                        busy,
  output logic                        done,
  output logic                        erase_fail,
  output logic                        timeout,
  output logic [7:0]                  status_byte
);
  seq_state_t            state;
  logic [BLK_W-1:0]      blk_q [MAX_PLANES];
  logic [PL_W-1:0]       last_q;
  logic [PL_W-1:0]       pidx;
  logic [AIDX_W-1:0]     aidx;
  logic                  sten_q;
  logic                  alt_q;
  logic                  bus_st;
  logic                  rd_st;
  logic                  s_active, s_sample, s_fin;
  logic                  rbw_ok, rbw_exp;
  logic [ADDR_CYC*8-1:0] addr_bytes;
  logic [7:0]            addr_byte;

  assign bus_st = (state == ST_SETUP) || (state == ST_ADDR) || (state == ST_CONF) ||
                  (state == ST_STCMD) || (state == ST_STRD);
  assign rd_st  = (state == ST_STRD);

  nand_strobe #(.LOW_CYC(WE_LOW), .HIGH_CYC(WE_HIGH)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bus_st && !s_active),
    .rd     (rd_st),
    .active (s_active),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .sample (s_sample),
    .fin    (s_fin)
  );

  nand_rb_wait #(.WB_CYC(WB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_rbw (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   ((state == ST_CONF) && s_fin),
    .rb_n    (nand_rb_n),
    .ok      (rbw_ok),
    .expired (rbw_exp)
  );

  nand_addr_pack #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .ADDR_CYC(ADDR_CYC)) u_pack (
    .blk     (blk_q[pidx]),
    .bytes_o (addr_bytes)
  );

  assign addr_byte = addr_bytes[8*aidx +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      last_q      <= '0;
      pidx        <= '0;
      aidx        <= '0;
      sten_q      <= 1'b0;
      alt_q       <= 1'b0;
      erase_fail  <= 1'b0;
      timeout     <= 1'b0;
      status_byte <= '0;
      for (int i = 0; i < MAX_PLANES; i++) blk_q[i] <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          for (int i = 0; i < MAX_PLANES; i++) blk_q[i] <= req_blocks[i*BLK_W +: BLK_W];
          last_q      <= req_planes;
          sten_q      <= req_status_en;
          alt_q       <= cfg_status_alt;
          pidx        <= '0;
          aidx        <= '0;
          erase_fail  <= 1'b0;
          timeout     <= 1'b0;
          status_byte <= '0;
          state       <= ST_SETUP;
        end
        ST_SETUP: if (s_fin) begin
          aidx  <= '0;
          state <= ST_ADDR;
        end
        ST_ADDR: if (s_fin) begin
          if (aidx == AIDX_W'(ADDR_CYC - 1)) begin
            if (pidx == last_q) begin
              state <= ST_CONF;
            end else begin
              pidx  <= pidx + 1'b1;
              state <= ST_SETUP;
            end
          end else begin
            aidx <= aidx + 1'b1;
          end
        end
        ST_CONF: if (s_fin) state <= ST_WAIT;
        ST_WAIT: begin
          if (rbw_ok) begin
            state <= sten_q ? ST_STCMD : ST_FIN;
          end else if (rbw_exp) begin
            timeout <= 1'b1;
            state   <= ST_FIN;
          end
        end
        ST_STCMD: if (s_fin) state <= ST_STRD;
        ST_STRD: begin
          if (s_sample) status_byte <= nand_dq_in;
          if (s_fin) begin
            erase_fail <= status_byte[0];
            state      <= ST_FIN;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    nand_dq_out = 8'h00;
    case (state)
      ST_SETUP: nand_dq_out = CMD_ERASE_SETUP;
      ST_ADDR:  nand_dq_out = addr_byte;
      ST_CONF:  nand_dq_out = CMD_ERASE_GO;
      ST_STCMD: nand_dq_out = alt_q ? CMD_STAT_ALT : CMD_STAT;
      default:  nand_dq_out = 8'h00;
    endcase
  end

  assign nand_cle   = (state == ST_SETUP) || (state == ST_CONF) || (state == ST_STCMD);
  assign nand_ale   = (state == ST_ADDR);
  assign nand_dq_oe = nand_cle || nand_ale;
  assign nand_ce_n  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign req_ready  = (state == ST_IDLE);
  assign done       = (state == ST_FIN);
endmodule

// File: rtl/nand_erase_seq_chk.sv
module nand_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic busy,
  input logic done,
  input logic erase_fail,
  input logic timeout
);
  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale));
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!nand_we_n && !nand_re_n));
  // R12
  we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_dq_oe && !nand_ce_n));
  // R9
  re_released_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_dq_oe && !nand_ce_n));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  timeout_no_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> !erase_fail);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(erase_fail) && $stable(timeout)));
  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale));
endmodule

bind nand_erase_seq nand_erase_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .busy       (busy),
  .done       (done),
  .erase_fail (erase_fail),
  .timeout    (timeout)
);

// File: tb/nand_erase_seq_tb_top.sv
module nand_erase_seq_tb_top;
  localparam int BW  = 9;
  localparam int MP  = 4;
  localparam int TOC = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_planes = '0;
  logic [MP*BW-1:0] req_blocks = '0;
  logic          req_status_en = 1'b0;
  logic          cfg_status_alt = 1'b0;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]    nand_dq_out, nand_dq_in;
  logic          nand_rb_n = 1'b1;
  logic          busy, done, erase_fail, timeout;
  logic [7:0]    status_byte;

  logic [7:0]    stat_val = 8'h00;
  bit            hang = 1'b0;
  int            cyc = 0;
  int            checks = 0;
  int            fails = 0;
  int            rb_rise = -1;
  int            go_cyc = -1;
  logic [1:0]    lg_kind [64];
  logic [7:0]    lg_byte [64];
  int            lg_cyc  [64];
  int            lg_n = 0;
  event          go_ev;

  always #10 clk = ~clk;

  nand_erase_seq #(.MAX_PLANES(MP), .BLK_W(BW), .PAGE_W(4), .WE_LOW(2), .WE_HIGH(1),
                   .WB_CYC(6), .TIMEOUT_CYC(TOC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_planes(req_planes), .req_blocks(req_blocks), .req_status_en(req_status_en),
    .cfg_status_alt(cfg_status_alt), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb_n(nand_rb_n), .busy(busy), .done(done), .erase_fail(erase_fail),
    .timeout(timeout), .status_byte(status_byte));

  assign nand_dq_in = nand_re_n ? 8'h00 : stat_val;

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary_and_end();
    end
  end

  // flash write-latch recorder
  always @(posedge nand_we_n) begin
    if (rst_n === 1'b1 && nand_ce_n === 1'b0 && lg_n < 64) begin
      lg_kind[lg_n] = {nand_cle, nand_ale};
      lg_byte[lg_n] = nand_dq_out;
      lg_cyc[lg_n]  = cyc;
      if (nand_cle && nand_dq_out == 8'hD0) begin
        go_cyc = cyc;
        -> go_ev;
      end
      lg_n++;
    end
  end

  // flash busy model
  initial begin
    forever begin
      @(go_ev);
      repeat (2) @(posedge clk);
      nand_rb_n = 1'b0;
      repeat (20) @(posedge clk);
      wait (!hang);
      @(posedge clk);
      nand_rb_n = 1'b1;
      rb_rise = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] blk_of(input int base, input int p);
    return BW'((base * 37 + p * 151 + 11) % 512);
  endfunction

  task automatic run_case(input int np, input logic [MP*BW-1:0] blks, input bit sten,
                          input bit alt, input logic [7:0] sv, input bit hng, input bit intf);
    logic [1:0] ek [64];
    logic [7:0] eb [64];
    int en = 0;
    int n = 0;
    int dcyc;
    bit seen_stat = 0;
    int stat_cyc = -1;
    lg_n = 0; stat_val = sv; hang = hng; rb_rise = -1; go_cyc = -1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready when idle", req_ready, 1);
    req_valid = 1'b1; req_planes = 2'(np - 1); req_blocks = blks;
    req_status_en = sten; cfg_status_alt = alt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && req_ready === 1'b0, "R2", "busy after accept", busy, 1);
    if (intf) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_planes = 2'd3; req_blocks = ~blks;
      req_status_en = ~sten; cfg_status_alt = ~alt;
      @(negedge clk);
      chk(req_ready === 1'b0, "R2", "ready while busy", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    dcyc = cyc;
    chk(done === 1'b1, "R11", "done raised", done, 1);
    chk(timeout === hng, "R10", "timeout flag", timeout, hng);
    chk(erase_fail === (sten && !hng && sv[0]), "R9", "erase_fail", erase_fail,
        sten && !hng && sv[0]);
    chk(status_byte === ((sten && !hng) ? sv : 8'h00), "R9", "status byte", status_byte,
        (sten && !hng) ? sv : 8'h00);
    for (int p = 0; p < np; p++) begin
      logic [BW-1:0] b;
      b = blks[p*BW +: BW];
      ek[en] = 2'b10; eb[en] = 8'h60; en++;
      ek[en] = 2'b01; eb[en] = {b[3:0], 4'b0000}; en++;
      ek[en] = 2'b01; eb[en] = {3'b000, b[8:4]}; en++;
    end
    ek[en] = 2'b10; eb[en] = 8'hD0; en++;
    if (sten && !hng) begin
      ek[en] = 2'b10; eb[en] = alt ? 8'h71 : 8'h70; en++;
    end
    chk(lg_n == en, "R5", "bus cycle count", lg_n, en);
    for (int i = 0; i < en && i < lg_n; i++) begin
      if (eb[i] == 8'h60 && ek[i] == 2'b10)
        chk(lg_kind[i] == ek[i] && lg_byte[i] == eb[i], "R3", "setup cmd",
            {lg_kind[i], lg_byte[i]}, {ek[i], eb[i]});
      else if (ek[i] == 2'b01)
        chk(lg_kind[i] == ek[i] && lg_byte[i] == eb[i], "R4", "address byte",
            {lg_kind[i], lg_byte[i]}, {ek[i], eb[i]});
      else if (eb[i] == 8'hD0)
        chk(lg_kind[i] == ek[i] && lg_byte[i] == eb[i], "R6", "confirm cmd",
            {lg_kind[i], lg_byte[i]}, {ek[i], eb[i]});
      else begin
        chk(lg_kind[i] == ek[i] && lg_byte[i] == eb[i], "R8", "status cmd",
            {lg_kind[i], lg_byte[i]}, {ek[i], eb[i]});
        seen_stat = 1; stat_cyc = lg_cyc[i];
      end
    end
    if (!hng) begin
      chk(rb_rise >= 0 && dcyc > rb_rise, "R7", "done after ready", dcyc, rb_rise);
      if (seen_stat)
        chk(stat_cyc > rb_rise, "R7", "status cmd after ready", stat_cyc, rb_rise);
    end else begin
      chk(go_cyc >= 0 && dcyc - go_cyc >= TOC, "R10", "timeout span", dcyc - go_cyc, TOC);
    end
    @(negedge clk);
    chk(done === 1'b0, "R11", "done one cycle", done, 0);
    chk(timeout === hng && status_byte === ((sten && !hng) ? sv : 8'h00), "R11",
        "results held", status_byte, (sten && !hng) ? sv : 8'h00);
    chk(req_ready === 1'b1 && busy === 1'b0, "R1", "idle after done", busy, 0);
    if (hng) begin
      hang = 1'b0;
      wait (nand_rb_n === 1'b1);
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(nand_ce_n === 1 && nand_we_n === 1 && nand_re_n === 1, "R1", "strobes in reset",
        {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nand_cle === 0 && nand_ale === 0 && busy === 0 && req_ready === 1 && done === 0,
        "R1", "idle pins", {nand_cle, nand_ale, busy, req_ready, done}, 5'b00010);
    for (int np = 1; np <= 4; np++) begin
      for (int m = 0; m < 4; m++) begin
        logic [MP*BW-1:0] bl;
        for (int p = 0; p < MP; p++) bl[p*BW +: BW] = blk_of(np * 4 + m, p);
        run_case(np, bl, m[0], m[1], 8'(8'hC0 | ((np + m) & 1)), 1'b0, 1'b0);
      end
    end
    // R4 address packing at the block range edges
    run_case(4, {9'h1FF, 9'h000, 9'h1FF, 9'h000}, 1'b1, 1'b0, 8'hE0, 1'b0, 1'b0);
    run_case(2, {18'h0, 9'h100, 9'h00F}, 1'b1, 1'b1, 8'hE1, 1'b0, 1'b0);
    // R2 request offered mid-sequence must be dropped
    run_case(2, {18'h0, 9'h0A5, 9'h15A}, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1);
    // R10 busy line never returns
    run_case(3, {9'h0, 9'h033, 9'h044, 9'h055}, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0);
    // recovery after timeout
    run_case(1, {27'h0, 9'h123}, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    summary_and_end();
  end
endmodule